// File: doc/BRIEF.md
# Pulse-Density to PCM Sinc Decimator

This block takes a 1-bit oversampled pulse-density stream, one bit per clock, and turns it into multi-bit PCM words at a rate that is lower by a fixed decimation ratio. Each PCM word is the input bitstream passed through a cascade of ORDER boxcar (moving-sum) filters, each RATIO samples long. The word is sampled once at the end of every decimation interval. Averaging the high-rate stream this way gives up output rate and gains amplitude resolution.

The structure depends on ORDER. With ORDER = 1 the block is a plain counter of high bits that is cleared at each interval boundary. With ORDER from 2 to 4 it uses the integrator–comb arrangement. ORDER accumulators run at the input rate and are chained without pipeline registers, so every one of them reflects the current bit. At each interval boundary their last value passes through ORDER first-difference stages, each with a differential delay of one output sample. All arithmetic wraps in two's complement. The word width is 1 + ORDER·log2(RATIO), so the wrap never corrupts a result. An input bit of 1 counts as 1 and a bit of 0 counts as 0. The PCM word is therefore unsigned, runs from 0 to RATIO^ORDER, and has its mid-scale at RATIO^ORDER/2.

Top module: `pdm_sinc_decimator`

## Requirements
- R1: Every rising clock edge out of reset takes one input bit. A 1 contributes a value of 1 and a 0 contributes 0.
- R2: After reset, pcm_valid is high for exactly one cycle in every RATIO cycles. It first rises in the cycle after the edge that takes the RATIO-th sample, and then follows each later edge that takes the last sample of an interval.
- R3: With ORDER = 1, each PCM word equals the number of 1 bits among the RATIO samples of the interval that just ended.
- R4: With ORDER > 1, each PCM word equals the sum over k of h[k]·x[n−k], where x[n] is the last sample of the interval and h is ORDER boxcars of length RATIO convolved together. Samples taken before reset count as 0.
- R5: A constant stream of 1 bits settles to the full-scale word RATIO^ORDER, and no PCM word ever exceeds RATIO^ORDER.
- R6: An alternating 1,0 stream settles to the mid-scale word RATIO^ORDER/2.
- R7: After a step from all-0 to all-1 input at an interval boundary, the ORDER-th word after the step is the first to reach full scale. With ORDER = 1 that is the first word.
- R8: An all-0 stream gives the word 0.
- R9: pcm_data holds its value in every cycle where pcm_valid is low.
- R10: While rst_n is low, pcm_valid is 0 and pcm_data is 0.
- R11: The PCM word is 1 + ORDER·log2(RATIO) bits wide. RATIO must be a power of two.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input-rate clock; one PDM bit per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pdm_bit | input | 1 | Pulse-density input bit |
| pcm_data | output | 1+ORDER·log2(RATIO) | Decimated PCM word, unsigned |
| pcm_valid | output | 1 | One-cycle strobe marking a new pcm_data word |

## Verification
The embedded properties check the following on every cycle:
- the interval phase wraps at the right count;
- the strobe never lasts more than one cycle and always coincides with phase zero;
- the word holds between strobes;
- no word exceeds full scale;
- the first accumulator never moves by more than one per cycle;
- the comb delay line changes only at an interval boundary;
- in first-order mode, the running count never exceeds the number of samples taken so far.

Whether each word has the correct value can only be shown by the bench. It compares every word against a direct convolution of the bit history with the cascaded boxcar kernel, for both a third-order and a first-order instance. It also checks the step-settling count, the mid-scale result for an alternating stream, and the all-zero and all-one limits.

// File: rtl/pdm_dec_pkg.sv
package pdm_dec_pkg;

    // Word width that holds RATIO^ORDER exactly
    function automatic int dec_width(input int order, input int ratio);
        return 1 + order * $clog2(ratio);
    endfunction

    // Full-scale output value RATIO^ORDER
    function automatic longint full_scale(input int order, input int ratio);
        longint acc;
        acc = 1;
        for (int i = 0; i < order; i++) begin
            acc = acc * ratio;
        end
        return acc;
    endfunction

endpackage

// File: rtl/pdm_dec_phase.sv
module pdm_dec_phase #(
    parameter  int RATIO = 8,
    localparam int CW    = (RATIO > 1) ? $clog2(RATIO) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [CW-1:0] phase,
    output logic          tick
);
    localparam logic [CW-1:0] LAST = CW'(RATIO - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } phase_st_t;

    phase_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == LAST) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        phase = st_q.cnt;
        tick  = (st_q.cnt == LAST);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R2: the interval phase restarts after its last sample
    a_r2_phase_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == LAST) |=> (st_q.cnt == '0));

endmodule

// File: rtl/pdm_dec_boxcar.sv
module pdm_dec_boxcar #(
    parameter int RATIO = 8,
    parameter int W     = 4,
    parameter int CW    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bit_in,
    input  logic          tick,
    input  logic [CW-1:0] phase,
    output logic [W-1:0]  result
);
    typedef struct packed {
        logic [W-1:0] acc;
    } box_st_t;

    box_st_t      st_d, st_q;
    logic [W-1:0] sum;

    always_comb begin
        st_d   = st_q;
        sum    = st_q.acc + {{(W-1){1'b0}}, bit_in};
        st_d.acc = tick ? '0 : sum;
        result = sum;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R3: ones counted so far can never exceed samples taken in the interval
    a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.acc <= W'(phase));

endmodule

// File: rtl/pdm_dec_integrator.sv
module pdm_dec_integrator #(
    parameter int ORDER = 3,
    parameter int W     = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bit_in,
    output logic [W-1:0] result
);
    typedef logic [W-1:0] word_t;

    typedef struct packed {
        word_t [ORDER-1:0] stage;
    } int_st_t;

    int_st_t st_d, st_q;
    word_t   feed;

    // Unpipelined chain: each stage adds the next value of the one before
    always_comb begin
        st_d = st_q;
        feed = {{(W-1){1'b0}}, bit_in};
        for (int k = 0; k < ORDER; k++) begin
            st_d.stage[k] = st_q.stage[k] + feed;
            feed          = st_d.stage[k];
        end
        result = feed;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R1: the first accumulator advances by the input bit, 0 or 1
    a_r1_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (word_t'(st_q.stage[0] - $past(st_q.stage[0])) <= word_t'(1)));

endmodule

// File: rtl/pdm_dec_comb.sv
module pdm_dec_comb #(
    parameter int ORDER = 3,
    parameter int W     = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [W-1:0] sample,
    output logic [W-1:0] result
);
    typedef logic [W-1:0] word_t;

    typedef struct packed {
        word_t [ORDER-1:0] dly;
    } comb_st_t;

    comb_st_t st_d, st_q;
    word_t    diff;

    // First differences at the output rate, delay of one output sample
    always_comb begin
        st_d = st_q;
        diff = sample;
        for (int k = 0; k < ORDER; k++) begin
            if (tick) begin
                st_d.dly[k] = diff;
            end
            diff = diff - st_q.dly[k];
        end
        result = diff;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R9: comb delay line moves only at an interval boundary
    a_r9_delay_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(st_q.dly));

endmodule

// File: rtl/pdm_sinc_decimator.sv
module pdm_sinc_decimator #(
    parameter int ORDER = 3,
    parameter int RATIO = 8
) (
    input  logic                                            clk,
    input  logic                                            rst_n,
    input  logic                                            pdm_bit,
    output logic [pdm_dec_pkg::dec_width(ORDER, RATIO)-1:0] pcm_data,
    output logic                                            pcm_valid
);
    localparam int W  = pdm_dec_pkg::dec_width(ORDER, RATIO);
    localparam int CW = (RATIO > 1) ? $clog2(RATIO) : 1;
    localparam logic [W-1:0] FULL = W'(pdm_dec_pkg::full_scale(ORDER, RATIO));

    typedef struct packed {
        logic         valid;
        logic [W-1:0] data;
    } out_st_t;

    out_st_t       st_d, st_q;
    logic          tick;
    logic [CW-1:0] phase;
    logic [W-1:0]  filt;

    pdm_dec_phase #(.RATIO(RATIO)) u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .phase (phase),
        .tick  (tick)
    );

    generate
        if (ORDER == 1) begin : g_count
            pdm_dec_boxcar #(.RATIO(RATIO), .W(W), .CW(CW)) u_box (
                .clk    (clk),
                .rst_n  (rst_n),
                .bit_in (pdm_bit),
                .tick   (tick),
                .phase  (phase),
                .result (filt)
            );
        end else begin : g_cic
            logic [W-1:0] integ;
            pdm_dec_integrator #(.ORDER(ORDER), .W(W)) u_int (
                .clk    (clk),
                .rst_n  (rst_n),
                .bit_in (pdm_bit),
                .result (integ)
            );
            pdm_dec_comb #(.ORDER(ORDER), .W(W)) u_comb (
                .clk    (clk),
                .rst_n  (rst_n),
                .tick   (tick),
                .sample (integ),
                .result (filt)
            );
        end
    endgenerate

    always_comb begin
        st_d       = st_q;
        st_d.valid = tick;
        if (tick) begin
            st_d.data = filt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pcm_data  = st_q.data;
    assign pcm_valid = st_q.valid;

    // R2: strobe lasts one cycle
    a_r2_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (pcm_valid && RATIO > 1) |=> !pcm_valid);

    // R2: strobe appears only just after the phase wrapped
    a_r2_valid_phase: assert property (@(posedge clk) disable iff (!rst_n)
        pcm_valid |-> (phase == '0));

    // R5: no word beyond full scale
    a_r5_full_scale: assert property (@(posedge clk) disable iff (!rst_n)
        pcm_valid |-> (pcm_data <= FULL));

    // R9: word holds between strobes
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !pcm_valid |-> $stable(pcm_data));

endmodule

// File: tb/pdm_sinc_decimator_test.sv
module pdm_sinc_decimator_test;
    localparam int ORD  = 3;
    localparam int RAT  = 8;
    localparam int W3   = 1 + ORD * $clog2(RAT);
    localparam int W1   = 1 + $clog2(RAT);
    localparam int HLEN = ORD * (RAT - 1) + 1;
    localparam longint FULL3 = RAT * RAT * RAT;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pdm_bit = 1'b0;
    logic [W3-1:0] data3;
    logic          valid3;
    logic [W1-1:0] data1;
    logic          valid1;

    int checks = 0;
    int errors = 0;
    int hist [HLEN];
    int h    [HLEN];
    int samples = 0;
    int gap = 0;
    int outs = 0;
    longint last3 = 0;
    longint last1 = 0;
    logic [15:0] lfsr = 16'hACE1;
    bit done = 0;

    always #5 clk = ~clk;

    pdm_sinc_decimator #(.ORDER(ORD), .RATIO(RAT)) uut (
        .clk(clk), .rst_n(rst_n), .pdm_bit(pdm_bit),
        .pcm_data(data3), .pcm_valid(valid3));

    pdm_sinc_decimator #(.ORDER(1), .RATIO(RAT)) uut_first (
        .clk(clk), .rst_n(rst_n), .pdm_bit(pdm_bit),
        .pcm_data(data1), .pcm_valid(valid1));

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic longint model3();
        longint s = 0;
        for (int k = 0; k < HLEN; k++) s += longint'(h[k]) * hist[k];
        return s;
    endfunction

    function automatic longint model1();
        longint s = 0;
        for (int k = 0; k < RAT; k++) s += hist[k];
        return s;
    endfunction

    // Drive one bit, let one edge take it, compare at #1 after the edge
    task automatic push(input logic b);
        pdm_bit = b;
        @(posedge clk);
        #1;
        for (int k = HLEN - 1; k > 0; k--) hist[k] = hist[k-1];
        hist[0] = b;
        samples++;
        gap++;
        chk("R2 strobes of both orders coincide", valid1, valid3);
        if (valid3) begin
            outs++;
            chk("R2 strobe spacing", gap, RAT);
            gap = 0;
            chk("R4 cascaded boxcar word", data3, model3());
            chk("R3 ones count word", data1, model1());
            last3 = data3;
            last1 = data1;
        end else begin
            chk("R9 word held between strobes", data3, last3);
            chk("R9 first-order word held", data1, last1);
        end
    endtask

    task automatic test_reset();
        pdm_bit = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk("R10 valid in reset", valid3, 0);
        chk("R10 data in reset", data3, 0);
        chk("R10 first-order data in reset", data1, 0);
        rst_n = 1'b1;
    endtask

    task automatic test_zeros();
        for (int i = 0; i < 4 * RAT; i++) push(1'b0);
        chk("R8 zero input word", data3, 0);
        chk("R8 zero input first-order word", data1, 0);
        chk("R11 word width", $bits(data3), W3);
    endtask

    task automatic test_step();
        int idx = 0;
        while (samples % RAT != 0) push(1'b0);
        for (int i = 0; i < (ORD + 3) * RAT; i++) begin
            push(1'b1);
            if (valid3) begin
                idx++;
                if (idx == 1) chk("R7 first order settles in one word", data1, RAT);
                if (idx == ORD - 1) chk("R7 not yet full one word early", longint'(data3 != W3'(FULL3)), 1);
                if (idx == ORD) chk("R7 full scale at word ORDER", data3, FULL3);
                if (idx > ORD) chk("R5 stays at full scale", data3, FULL3);
            end
        end
    endtask

    task automatic test_alternating();
        for (int i = 0; i < 6 * RAT; i++) push(i[0] ? 1'b0 : 1'b1);
        chk("R6 mid-scale word", last3, FULL3 / 2);
        chk("R6 first-order mid-scale", last1, RAT / 2);
    endtask

    task automatic test_pattern();
        for (int i = 0; i < 20 * RAT; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            push(lfsr[0]);
        end
        // R1: bits are counted as 1/0, checked through the model on every word
    endtask

    task automatic test_ones_again();
        for (int i = 0; i < (ORD + 2) * RAT; i++) push(1'b1);
        chk("R5 full scale after arbitrary history", last3, FULL3);
        chk("R5 first-order full scale", last1, RAT);
    endtask

    initial begin
        for (int k = 0; k < HLEN; k++) begin
            hist[k] = 0;
            h[k] = (k < RAT) ? 1 : 0;
        end
        for (int p = 1; p < ORD; p++) begin
            int tmp [HLEN];
            for (int k = 0; k < HLEN; k++) begin
                tmp[k] = 0;
                for (int j = 0; j < RAT && j <= k; j++) tmp[k] += h[k-j];
            end
            for (int k = 0; k < HLEN; k++) h[k] = tmp[k];
        end
        test_reset();
        test_zeros();
        test_step();
        test_alternating();
        test_pattern();
        test_ones_again();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule